// File: doc/BRIEF.md
# Thirty-Cent Drink Vending Controller

This block sequences a drink machine that sells one item at a fixed price of 30 cents. Each clock cycle it looks at three coin pulses (nickel, dime, quarter), keeps the running credit in its state, and once the credit reaches or passes the price it releases one can. Any overpayment comes back over the following cycles, one coin per cycle, as dimes first and then a nickel if needed. After that the machine returns to idle.

The controller is a Moore machine with fifteen states held in a 4-bit register. The three dispense outputs are registers loaded from the next-state value. They therefore line up with the state the machine has just entered, and they cannot glitch while several state bits change at once. The current state code is also driven onto a port for observation. Coins that arrive while the machine is releasing a can or returning change are discarded.

Top module: `vend_ctrl`

## Requirements
- R1: When rst_n is sampled low at a rising clock edge, the state becomes idle (code 0) and all three dispense outputs become 0. Reset is synchronous and active low.
- R2: In idle or in a credit state with code k from 1 to 5 (credit 5k cents), a nickel moves the state to k+1, a dime to k+2 and a quarter to k+5 at the next edge.
- R3: If more than one coin is asserted in the same cycle, a quarter wins over a dime and a dime wins over a nickel.
- R4: In idle or a credit state, a cycle with no coin leaves the state unchanged.
- R5: vend_can is 1 exactly while the state is one of the purchase codes 6 to 10 (30 to 50 cents of credit). Each of these states lasts a single cycle.
- R6: Purchase codes move on regardless of the inputs: 6 goes to idle, 7 to code 14, 8 to code 13, 9 to code 12, and 10 to code 11.
- R7: The return codes are 11 (20 cents owed), 12 (15), 13 (10) and 14 (5). Codes 11, 12 and 13 assert give_dime, and code 14 asserts give_nickel. The moves are 11 to 13, 12 to 14, and 13 and 14 to idle.
- R8: Coins asserted while the state is a purchase or return code do not change the next state.
- R9: At most one of the three dispense outputs is 1 in any cycle. Each output is a register that changes only at a clock edge, and it always matches the state code it belongs to.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| coin_nickel | input | 1 | Nickel inserted this cycle |
| coin_dime | input | 1 | Dime inserted this cycle |
| coin_quarter | input | 1 | Quarter inserted this cycle |
| vend_can | output | 1 | Release one can (registered) |
| give_dime | output | 1 | Return one dime (registered) |
| give_nickel | output | 1 | Return one nickel (registered) |
| state_obs | output | 4 | Current state code |

## Verification
The credit path is driven with all-nickel, all-dime and quarter-based coin sequences. Each of the five purchase totals (30, 35, 40, 45 and 50 cents) is reached, so every change route is taken and the exact dime/nickel order is seen cycle by cycle. Simultaneous coins separate the three priority levels. Idle cycles separate holding from drifting. Coins injected during purchase and return states show whether the change sequence can be disturbed. A reset in the middle of a run confirms that any credit is abandoned.

// File: rtl/vend_pkg.sv
// Package: shared widths, state codes and helper functions for the vending controller.
// Assumes: credit states are numbered in 5-cent units so that arithmetic on the code is credit arithmetic.
package vend_pkg;

    localparam int STATE_W = 4;
    localparam int UNIT_W  = 3;

    localparam logic [STATE_W-1:0] ST_IDLE       = 4'd0;
    localparam logic [STATE_W-1:0] ST_CREDIT_TOP = 4'd5;
    localparam logic [STATE_W-1:0] ST_BUY_LO     = 4'd6;
    localparam logic [STATE_W-1:0] ST_BUY_HI     = 4'd10;
    localparam logic [STATE_W-1:0] ST_RET20      = 4'd11;
    localparam logic [STATE_W-1:0] ST_RET15      = 4'd12;
    localparam logic [STATE_W-1:0] ST_RET10      = 4'd13;
    localparam logic [STATE_W-1:0] ST_RET5       = 4'd14;

    localparam logic [STATE_W-1:0] STEP_NICKEL  = 4'd1;
    localparam logic [STATE_W-1:0] STEP_DIME    = 4'd2;
    localparam logic [STATE_W-1:0] STEP_QUARTER = 4'd5;

    typedef enum logic [1:0] {
        COIN_NONE,
        COIN_NICKEL,
        COIN_DIME,
        COIN_QUARTER
    } coin_e;

    // Map a change amount in 5-cent units to the return state that pays it.
    function automatic logic [STATE_W-1:0] units_to_ret(input logic [UNIT_W-1:0] u);
        case (u)
            3'd1:    return ST_RET5;
            3'd2:    return ST_RET10;
            3'd3:    return ST_RET15;
            3'd4:    return ST_RET20;
            default: return ST_IDLE;
        endcase
    endfunction

    // Change still owed (5-cent units) in a return state; 0 elsewhere.
    function automatic logic [UNIT_W-1:0] ret_units(input logic [STATE_W-1:0] s);
        case (s)
            ST_RET20: return 3'd4;
            ST_RET15: return 3'd3;
            ST_RET10: return 3'd2;
            ST_RET5:  return 3'd1;
            default:  return 3'd0;
        endcase
    endfunction

    // True for the states that release a can.
    function automatic logic is_buy(input logic [STATE_W-1:0] s);
        return (s >= ST_BUY_LO) && (s <= ST_BUY_HI);
    endfunction

endpackage

// File: rtl/vend_coin_prio.sv
// Module: vend_coin_prio
// Reduces the three coin pulses to one coin choice, quarter over dime over nickel.
// Assumes: pulses are already synchronous to clk and one cycle wide.
module vend_coin_prio
    import vend_pkg::*;
(
    input  logic  nickel,
    input  logic  dime,
    input  logic  quarter,
    output coin_e coin
);

    // Priority select of the coin seen this cycle.
    always_comb begin
        if (quarter)     coin = COIN_QUARTER;
        else if (dime)   coin = COIN_DIME;
        else if (nickel) coin = COIN_NICKEL;
        else             coin = COIN_NONE;
    end

endmodule

// File: rtl/vend_next_state.sv
// Module: vend_next_state
// Next-state logic: adds credit, leaves purchase states, walks the change chain.
// Assumes: the current state comes from a register; unused codes recover to idle.
module vend_next_state
    import vend_pkg::*;
(
    input  logic [STATE_W-1:0] cur,
    input  coin_e              coin,
    output logic [STATE_W-1:0] nxt
);

    logic [STATE_W-1:0] step;
    logic [STATE_W-1:0] over;
    logic [UNIT_W-1:0]  owed;
    logic [UNIT_W-1:0]  left;

    // Credit increment for the selected coin.
    always_comb begin
        case (coin)
            COIN_QUARTER: step = STEP_QUARTER;
            COIN_DIME:    step = STEP_DIME;
            COIN_NICKEL:  step = STEP_NICKEL;
            default:      step = '0;
        endcase
    end

    // Overpayment in purchase states and change left after one return coin.
    always_comb begin
        over = cur - ST_BUY_LO;
        owed = ret_units(cur);
        left = (owed >= 3'd2) ? owed - 3'd2 : owed - 3'd1;
    end

    // State transition selection.
    always_comb begin
        if (cur <= ST_CREDIT_TOP)
            nxt = cur + step;
        else if (is_buy(cur))
            nxt = units_to_ret(over[UNIT_W-1:0]);
        else if (owed != '0)
            nxt = units_to_ret(left);
        else
            nxt = ST_IDLE;
    end

endmodule

// File: rtl/vend_out_reg.sv
// Module: vend_out_reg
// Registers the dispense outputs from the next state so they line up with the
// state register and cannot glitch.
// Assumes: loaded on the same edge and reset as the state register.
module vend_out_reg
    import vend_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STATE_W-1:0] nxt,
    output logic               can_q,
    output logic               dime_q,
    output logic               nickel_q
);

    logic [UNIT_W-1:0] nxt_owed;

    // Change owed by the state about to be entered.
    always_comb nxt_owed = ret_units(nxt);

    // Output registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            can_q    <= 1'b0;
            dime_q   <= 1'b0;
            nickel_q <= 1'b0;
        end else begin
            can_q    <= is_buy(nxt);
            dime_q   <= (nxt_owed >= 3'd2);
            nickel_q <= (nxt_owed == 3'd1);
        end
    end

    p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({can_q, dime_q, nickel_q}))
        else $error("more than one dispense output active");

endmodule

// File: rtl/vend_ctrl.sv
// Module: vend_ctrl (top)
// Moore vending controller: 30-cent price, coin credit, can release, change return.
// Assumes: at most one coin per cycle in normal use; synchronous active-low reset.
module vend_ctrl
    import vend_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               coin_nickel,
    input  logic               coin_dime,
    input  logic               coin_quarter,
    output logic               vend_can,
    output logic               give_dime,
    output logic               give_nickel,
    output logic [STATE_W-1:0] state_obs
);

    coin_e              coin;
    logic [STATE_W-1:0] state_q;
    logic [STATE_W-1:0] state_d;

    vend_coin_prio u_prio (
        .nickel  (coin_nickel),
        .dime    (coin_dime),
        .quarter (coin_quarter),
        .coin    (coin)
    );

    vend_next_state u_next (
        .cur  (state_q),
        .coin (coin),
        .nxt  (state_d)
    );

    vend_out_reg u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .nxt      (state_d),
        .can_q    (vend_can),
        .dime_q   (give_dime),
        .nickel_q (give_nickel)
    );

    // State register with synchronous reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign state_obs = state_q;

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (state_q == ST_IDLE) && !vend_can && !give_dime && !give_nickel)
        else $error("state not idle after reset");

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q <= ST_CREDIT_TOP) && !coin_nickel && !coin_dime && !coin_quarter
        |=> $stable(state_q))
        else $error("credit changed without a coin");

    p_can_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vend_can == ((state_q >= ST_BUY_LO) && (state_q <= ST_BUY_HI)))
        else $error("vend_can disagrees with state");

    p_exact_price_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUY_LO) |=> (state_q == ST_IDLE))
        else $error("exact price did not return to idle");

    p_ret20_chain_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RET20) |=> (state_q == ST_RET10))
        else $error("20-cent return did not go to 10-cent return");

    p_ignore_coin_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RET15) |=> (state_q == ST_RET5))
        else $error("15-cent return disturbed");

    p_nickel_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        give_nickel == (state_q == ST_RET5))
        else $error("give_nickel disagrees with state");

endmodule

// File: tb/vend_ctrl_test.sv
module vend_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nk = 1'b0, dm = 1'b0, qt = 1'b0;
    logic       can, gdime, gnick;
    logic [3:0] st;
    int         checks = 0;
    int         fails = 0;

    always #10 clk = ~clk;   // 50 MHz

    vend_ctrl uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .coin_nickel  (nk),
        .coin_dime    (dm),
        .coin_quarter (qt),
        .vend_can     (can),
        .give_dime    (gdime),
        .give_nickel  (gnick),
        .state_obs    (st)
    );

    // Compare state and outputs against expected values.
    task automatic expect_all(input string req, input logic [3:0] es,
                              input logic ec, input logic ed, input logic en);
        checks++;
        if (st !== es || can !== ec || gdime !== ed || gnick !== en) begin
            fails++;
            $display("FAIL %s: state=%0d can=%b dime=%b nickel=%b expected state=%0d can=%b dime=%b nickel=%b",
                     req, st, can, gdime, gnick, es, ec, ed, en);
        end
    endtask

    // Drive coins for one cycle; return at the next falling edge.
    task automatic tick(input logic n, input logic d, input logic q);
        nk = n; dm = d; qt = q;
        @(negedge clk);
        nk = 1'b0; dm = 1'b0; qt = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_all("R1 reset", 4'd0, 0, 0, 0);
    endtask

    task automatic t_nickels;
        for (int i = 1; i <= 5; i++) begin
            tick(1, 0, 0);
            expect_all("R2 nickel step", 4'(i), 0, 0, 0);
        end
        tick(1, 0, 0);
        expect_all("R5 can at 30", 4'd6, 1, 0, 0);
        tick(0, 0, 0);
        expect_all("R6 30 to idle", 4'd0, 0, 0, 0);
    endtask

    task automatic t_dimes;
        tick(0, 1, 0); expect_all("R2 dime step", 4'd2, 0, 0, 0);
        tick(0, 1, 0); expect_all("R2 dime step", 4'd4, 0, 0, 0);
        tick(0, 1, 0); expect_all("R5 can at 30 by dimes", 4'd6, 1, 0, 0);
        tick(0, 0, 0); expect_all("R6 idle", 4'd0, 0, 0, 0);
    endtask

    task automatic t_fifty;
        tick(0, 0, 1); expect_all("R2 quarter step", 4'd5, 0, 0, 0);
        tick(0, 0, 1); expect_all("R5 can at 50", 4'd10, 1, 0, 0);
        tick(0, 0, 0); expect_all("R7 ret20 dime", 4'd11, 0, 1, 0);
        tick(0, 0, 0); expect_all("R7 ret10 dime", 4'd13, 0, 1, 0);
        tick(0, 0, 0); expect_all("R7 idle after change", 4'd0, 0, 0, 0);
    endtask

    task automatic t_thirtyfive;
        tick(0, 1, 0); expect_all("R2 dime", 4'd2, 0, 0, 0);
        tick(0, 0, 1); expect_all("R5 can at 35", 4'd7, 1, 0, 0);
        tick(0, 0, 0); expect_all("R6 35 to ret5", 4'd14, 0, 0, 1);
        tick(0, 0, 0); expect_all("R7 idle", 4'd0, 0, 0, 0);
    endtask

    task automatic t_forty;
        tick(1, 0, 0); tick(0, 1, 0);
        expect_all("R2 fifteen", 4'd3, 0, 0, 0);
        tick(0, 0, 1); expect_all("R5 can at 40", 4'd8, 1, 0, 0);
        tick(0, 0, 0); expect_all("R6 40 to ret10", 4'd13, 0, 1, 0);
        tick(0, 0, 0); expect_all("R7 idle", 4'd0, 0, 0, 0);
    endtask

    task automatic t_fortyfive;
        tick(0, 1, 0); tick(0, 1, 0);
        tick(0, 0, 1); expect_all("R5 can at 45", 4'd9, 1, 0, 0);
        tick(0, 0, 0); expect_all("R6 45 to ret15", 4'd12, 0, 1, 0);
        tick(0, 0, 0); expect_all("R7 ret15 to ret5", 4'd14, 0, 0, 1);
        tick(0, 0, 0); expect_all("R9 idle, outputs clear", 4'd0, 0, 0, 0);
    endtask

    task automatic t_priority;
        tick(1, 1, 1); expect_all("R3 quarter wins", 4'd5, 0, 0, 0);
        t_reset();
        tick(1, 1, 0); expect_all("R3 dime over nickel", 4'd2, 0, 0, 0);
        tick(1, 0, 0); expect_all("R3 nickel alone", 4'd3, 0, 0, 0);
    endtask

    task automatic t_hold;
        repeat (4) tick(0, 0, 0);
        expect_all("R4 credit held", 4'd3, 0, 0, 0);
        t_reset();
        repeat (3) tick(0, 0, 0);
        expect_all("R4 idle held", 4'd0, 0, 0, 0);
    endtask

    task automatic t_ignore;
        tick(0, 0, 1); tick(0, 0, 1);
        expect_all("R8 at 50", 4'd10, 1, 0, 0);
        tick(0, 0, 1); expect_all("R8 quarter ignored in purchase", 4'd11, 0, 1, 0);
        tick(1, 0, 0); expect_all("R8 nickel ignored in ret20", 4'd13, 0, 1, 0);
        tick(0, 1, 0); expect_all("R8 dime ignored in ret10", 4'd0, 0, 0, 0);
    endtask

    task automatic t_mid_reset;
        tick(0, 1, 0); tick(1, 0, 0);
        expect_all("R2 before reset", 4'd3, 0, 0, 0);
        rst_n = 1'b0;
        tick(0, 0, 1);
        rst_n = 1'b1;
        expect_all("R1 mid-run reset, quarter dropped", 4'd0, 0, 0, 0);
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: timeout actual=expired expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_nickels();
        t_dimes();
        t_fifty();
        t_thirtyfive();
        t_forty();
        t_fortyfive();
        t_priority();
        t_reset();
        tick(1, 1, 0); tick(1, 0, 0);
        t_hold();
        t_ignore();
        t_mid_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule